// File: doc/BRIEF.md
# Data-Break Disk Word Sequencer

This block moves words between main memory and a head-per-track disk, one word at a time. It uses the multicycle data-break method. The transfer bookkeeping is kept in main memory, not in local registers. Two fixed memory words hold the state: one is a negative word count and the other is the current memory address. The sequencer steps both of them forward before it touches any data.

A transfer is launched with an operation code, a starting disk address and a burst flag. For each word the sequencer does the following, in order:

1. It checks the disk address against the configured capacity.
2. It reads, increments and writes back the count.
3. It reads, increments and writes back the address.
4. It performs the data move.
5. It advances the disk address.

The data move has three forms:
- **Read**: copies the disk word into memory.
- **Write**: copies the memory word to disk, unless the target track group is write-locked.
- **Check**: compares the memory word with the disk word.

The transfer ends on the first error, or when the count has wrapped to zero. The block then raises done.

Memory is reached through a request/ready handshake. The disk store is an array with an asynchronous read and a write strobe. In non-burst mode every word after the first waits for a word-slot strobe. Burst mode runs the words back to back.

Top module: `brk_xfer`

## Requirements
- R1: After reset, busy, done and the three error flags are 0, and no memory request is raised.
- R2: For every word, memory word 036 (octal) is read, incremented modulo 2^18 and written back. Memory word 037 (octal) is then read, incremented modulo 2^15 and written back. Both happen before the data move. The incremented address is the one used for the data move.
- R3: Operation code 1 (read) writes the disk word at the current disk address into memory at the incremented address.
- R4: Operation code 2 (write) writes the memory word at the incremented address to the disk at the current disk address.
- R5: Operation code 3 (check) compares the two words without writing either one. A mismatch sets err_wchk and ends the transfer, and the disk address is not advanced.
- R6: On a write, the lock bit is wlock[disk*16 + group], where disk is disk-address bits 20:18 and group is bits 17:14. If that bit is set, err_lock is raised and the transfer ends without writing the disk or memory, and without advancing the disk address. Read and check ignore the lock bits.
- R7: Capacity is (plat_m1+1)*2^18 words. The disk address is checked against it before each word. If the address is at or above capacity, err_nodisk is set and the transfer ends before the count is touched for that word.
- R8: The disk address (visible on dsk_addr) advances by one after every completed word. The transfer ends once the incremented count is zero. When it ends, for any reason, done is set, busy drops in the same cycle, and at most one error flag is set.
- R9: With burst low, each word after the first starts only after slot_strobe has been seen. With burst high, each next word starts without waiting.
- R10: A start while busy, or a start with operation code 0, is ignored.
- R11: A memory request holds its address, direction and write data stable until mem_ready is seen.
- R12: An accepted start clears done and all error flags in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| op | input | 2 | 0 none, 1 read, 2 write, 3 check |
| start_da | input | 21 | First disk address |
| plat_m1 | input | 3 | Number of platters minus one |
| burst | input | 1 | Run words back to back |
| slot_strobe | input | 1 | Word-slot pulse for non-burst mode |
| wlock | input | 128 | Lock bits, index disk*16+group |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 18 | Memory read data, valid with mem_ready |
| dsk_addr | output | 21 | Current disk address |
| dsk_we | output | 1 | Disk write strobe |
| dsk_wdata | output | 18 | Disk write data |
| dsk_rdata | input | 18 | Disk data at dsk_addr |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| err_wchk | output | 1 | Check mismatch |
| err_lock | output | 1 | Write to a locked group |
| err_nodisk | output | 1 | Address beyond capacity |

## Verification
The handshake property assumes that the lock bits do not change while a transfer is running. A lock bit that moves during a write would withdraw a pending request. The capacity and lock properties assume that plat_m1 and wlock describe the transfer that is actually running. The bench changes wlock and plat_m1 only while the block is idle. It also drives mem_ready only together with a request and lets it drop on alternate cycles, which exercises held requests.

// File: rtl/brk_xfer_pkg.sv
package brk_xfer_pkg;
  localparam int WORD_W  = 18;
  localparam int MEM_AW  = 15;
  localparam int DISK_W  = 3;
  localparam int TRK_W   = 7;
  localparam int WRD_W   = 11;
  localparam int GRP_W   = 4;
  localparam int PLAT_SH = TRK_W + WRD_W;
  localparam int DA_W    = DISK_W + PLAT_SH;
  localparam int NDISK   = 1 << DISK_W;
  localparam int NGRP    = 1 << GRP_W;
  localparam int LOCK_W  = NDISK * NGRP;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CHECK = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RDWC, S_WRWC, S_RDCA, S_WRCA, S_MOVE, S_ADV, S_WAIT
  } st_e;

  function automatic logic [WORD_W-1:0] wc_step(input logic [WORD_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [MEM_AW-1:0] ca_step(input logic [MEM_AW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DA_W:0] cap_words(input logic [DISK_W-1:0] pm1);
    logic [DA_W:0] n;
    n = (DA_W+1)'(pm1) + 1'b1;
    return n << PLAT_SH;
  endfunction

  function automatic logic [DISK_W+GRP_W-1:0] lock_index(input logic [DA_W-1:0] da);
    return {da[DA_W-1 -: DISK_W], da[PLAT_SH-1 -: GRP_W]};
  endfunction
endpackage

// File: rtl/brk_xfer_bound.sv
module brk_xfer_bound
  import brk_xfer_pkg::*;
(
  input  logic [DA_W-1:0]   da,
  input  logic [DISK_W-1:0] plat_m1,
  output logic              ned_hit
);
  logic [DA_W:0] limit;
  assign limit   = cap_words(plat_m1);
  assign ned_hit = {1'b0, da} >= limit;
endmodule

// File: rtl/brk_xfer_lock.sv
module brk_xfer_lock
  import brk_xfer_pkg::*;
(
  input  logic [LOCK_W-1:0] wlock,
  input  logic [DISK_W-1:0] disk_sel,
  input  logic [GRP_W-1:0]  grp_sel,
  output logic              lock_hit
);
  logic [NDISK-1:0] hit;

  for (genvar d = 0; d < NDISK; d++) begin : g_disk
    logic [NGRP-1:0] row;
    assign row    = wlock[d*NGRP +: NGRP];
    assign hit[d] = (disk_sel == DISK_W'(d)) && row[grp_sel];
  end

  assign lock_hit = |hit;
endmodule

// File: rtl/brk_xfer_memif.sv
module brk_xfer_memif
  import brk_xfer_pkg::*;
#(
  parameter int unsigned WC_LOC = 'o36,
  parameter int unsigned CA_LOC = 'o37
) (
  input  st_e               st,
  input  op_e               op,
  input  logic [WORD_W-1:0] wc,
  input  logic [MEM_AW-1:0] ca,
  input  logic              lock_hit,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] dsk_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              dsk_we,
  output logic [WORD_W-1:0] dsk_wdata
);
  assign dsk_wdata = mem_rdata;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    dsk_we    = 1'b0;
    unique case (st)
      S_RDWC: begin
        mem_req  = 1'b1;
        mem_addr = MEM_AW'(WC_LOC);
      end
      S_WRWC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = MEM_AW'(WC_LOC);
        mem_wdata = wc;
      end
      S_RDCA: begin
        mem_req  = 1'b1;
        mem_addr = MEM_AW'(CA_LOC);
      end
      S_WRCA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = MEM_AW'(CA_LOC);
        mem_wdata = WORD_W'(ca);
      end
      S_MOVE: begin
        unique case (op)
          OP_READ: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ca;
            mem_wdata = dsk_rdata;
          end
          OP_WRITE: begin
            if (!lock_hit) begin
              mem_req  = 1'b1;
              mem_addr = ca;
              dsk_we   = mem_ready;
            end
          end
          OP_CHECK: begin
            mem_req  = 1'b1;
            mem_addr = ca;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brk_xfer.sv
module brk_xfer
  import brk_xfer_pkg::*;
#(
  parameter int unsigned WC_LOC = 'o36,
  parameter int unsigned CA_LOC = 'o37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DA_W-1:0]   start_da,
  input  logic [DISK_W-1:0] plat_m1,
  input  logic              burst,
  input  logic              slot_strobe,
  input  logic [LOCK_W-1:0] wlock,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [DA_W-1:0]   dsk_addr,
  output logic              dsk_we,
  output logic [WORD_W-1:0] dsk_wdata,
  input  logic [WORD_W-1:0] dsk_rdata,
  output logic              busy,
  output logic              done,
  output logic              err_wchk,
  output logic              err_lock,
  output logic              err_nodisk
);
  st_e               st;
  op_e               op_q;
  logic [DA_W-1:0]   da_q;
  logic [DISK_W-1:0] plat_q;
  logic              burst_q;
  logic [WORD_W-1:0] wc_q;
  logic [MEM_AW-1:0] ca_q;
  logic              done_q, e_wchk, e_lock, e_ned;

  // named events for the checker
  logic ned_hit, lock_hit, mem_fire, wchk_miss, word_start, launch;

  assign mem_fire   = mem_req & mem_ready;
  assign wchk_miss  = mem_rdata != dsk_rdata;
  assign word_start = (st == S_CHK);
  assign launch     = (st == S_IDLE) && start && (op != 2'(OP_NONE));

  brk_xfer_bound u_bound (
    .da      (da_q),
    .plat_m1 (plat_q),
    .ned_hit (ned_hit)
  );

  brk_xfer_lock u_lock (
    .wlock    (wlock),
    .disk_sel (da_q[DA_W-1 -: DISK_W]),
    .grp_sel  (da_q[PLAT_SH-1 -: GRP_W]),
    .lock_hit (lock_hit)
  );

  brk_xfer_memif #(.WC_LOC(WC_LOC), .CA_LOC(CA_LOC)) u_memif (
    .st        (st),
    .op        (op_q),
    .wc        (wc_q),
    .ca        (ca_q),
    .lock_hit  (lock_hit),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .dsk_rdata (dsk_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dsk_we    (dsk_we),
    .dsk_wdata (dsk_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_NONE;
      da_q    <= '0;
      plat_q  <= '0;
      burst_q <= 1'b0;
      wc_q    <= '0;
      ca_q    <= '0;
      done_q  <= 1'b0;
      e_wchk  <= 1'b0;
      e_lock  <= 1'b0;
      e_ned   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (launch) begin
          op_q    <= op_e'(op);
          da_q    <= start_da;
          plat_q  <= plat_m1;
          burst_q <= burst;
          done_q  <= 1'b0;
          e_wchk  <= 1'b0;
          e_lock  <= 1'b0;
          e_ned   <= 1'b0;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (ned_hit) begin
            e_ned  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RDWC;
          end
        end
        S_RDWC: if (mem_fire) begin
          wc_q <= wc_step(mem_rdata);
          st   <= S_WRWC;
        end
        S_WRWC: if (mem_fire) st <= S_RDCA;
        S_RDCA: if (mem_fire) begin
          ca_q <= ca_step(mem_rdata[MEM_AW-1:0]);
          st   <= S_WRCA;
        end
        S_WRCA: if (mem_fire) st <= S_MOVE;
        S_MOVE: begin
          unique case (op_q)
            OP_WRITE: begin
              if (lock_hit) begin
                e_lock <= 1'b1;
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else if (mem_fire) begin
                st <= S_ADV;
              end
            end
            OP_CHECK: begin
              if (mem_fire) begin
                if (wchk_miss) begin
                  e_wchk <= 1'b1;
                  done_q <= 1'b1;
                  st     <= S_IDLE;
                end else begin
                  st <= S_ADV;
                end
              end
            end
            default: if (mem_fire) st <= S_ADV;
          endcase
        end
        S_ADV: begin
          da_q <= da_q + 1'b1;
          if (wc_q == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (burst_q) begin
            st <= S_CHK;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (slot_strobe) st <= S_CHK;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dsk_addr   = da_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err_wchk   = e_wchk;
  assign err_lock   = e_lock;
  assign err_nodisk = e_ned;
endmodule

// File: rtl/brk_xfer_chk.sv
module brk_xfer_chk
  import brk_xfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              slot_strobe,
  input logic [LOCK_W-1:0] wlock,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [DA_W-1:0]   dsk_addr,
  input logic              dsk_we,
  input logic              busy,
  input logic              done,
  input logic              err_wchk,
  input logic              err_lock,
  input logic              err_nodisk,
  input logic              word_start,
  input logic              burst_q,
  input logic [DISK_W-1:0] plat_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !mem_req);

  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_no_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_we |-> !wlock[lock_index(dsk_addr)]);

  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_we |-> ({1'b0, dsk_addr} < cap_words(plat_q)));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_one_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_wchk, err_lock, err_nodisk}));

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_slot_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_start && $past(busy) && !burst_q |-> $past(slot_strobe));
endmodule

bind brk_xfer brk_xfer_chk u_brk_xfer_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .slot_strobe (slot_strobe),
  .wlock       (wlock),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ready   (mem_ready),
  .dsk_addr    (dsk_addr),
  .dsk_we      (dsk_we),
  .busy        (busy),
  .done        (done),
  .err_wchk    (err_wchk),
  .err_lock    (err_lock),
  .err_nodisk  (err_nodisk),
  .word_start  (word_start),
  .burst_q     (burst_q),
  .plat_q      (plat_q)
);

// File: tb/brk_xfer_bench.sv
module brk_xfer_bench;
  import brk_xfer_pkg::*;

  localparam logic [11:0] WCA = 12'o36;
  localparam logic [11:0] CAA = 12'o37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [DA_W-1:0] start_da = '0;
  logic [DISK_W-1:0] plat_m1 = 3'd7;
  logic burst = 1'b1;
  logic slot_strobe = 1'b0;
  logic [LOCK_W-1:0] wlock = '0;
  logic mem_req, mem_we, mem_ready, dsk_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata, dsk_wdata, dsk_rdata;
  logic [DA_W-1:0] dsk_addr;
  logic busy, done, err_wchk, err_lock, err_nodisk;

  logic [WORD_W-1:0] mem [0:4095];
  logic [WORD_W-1:0] dsk [0:4095];
  logic rdy_gate = 1'b1;
  logic strobe_en = 1'b0;
  int   strobe_cnt = 0;
  int   n_checks = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [11:0] didx(input logic [DA_W-1:0] a);
    return {a[DA_W-1 -: DISK_W], a[8:0]};
  endfunction

  assign mem_ready = mem_req & rdy_gate;
  assign mem_rdata = mem[mem_addr[11:0]];
  assign dsk_rdata = dsk[didx(dsk_addr)];

  initial forever begin
    @(posedge clk);
    if (mem_req && mem_ready && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (dsk_we) dsk[didx(dsk_addr)] <= dsk_wdata;
  end

  always @(negedge clk) begin
    rdy_gate <= ~rdy_gate;
    if (strobe_en) begin
      strobe_cnt  <= (strobe_cnt == 6) ? 0 : strobe_cnt + 1;
      slot_strobe <= (strobe_cnt == 6);
    end else begin
      slot_strobe <= 1'b0;
    end
  end

  brk_xfer u_brk_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .start_da(start_da),
    .plat_m1(plat_m1), .burst(burst), .slot_strobe(slot_strobe), .wlock(wlock),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .dsk_addr(dsk_addr), .dsk_we(dsk_we),
    .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata), .busy(busy), .done(done),
    .err_wchk(err_wchk), .err_lock(err_lock), .err_nodisk(err_nodisk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic launch(input logic [1:0] o, input logic [DA_W-1:0] da, input logic b);
    @(negedge clk);
    op = o; start_da = da; burst = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R8", "watchdog, transfer never finished", 0, 1);
  endtask

  task automatic set_ctl(input logic [WORD_W-1:0] wc0, input logic [WORD_W-1:0] ca0);
    mem[WCA] = wc0;
    mem[CAA] = ca0;
  endtask

  task automatic chk_errs(input string req, input logic [2:0] exp);
    chk_eq(req, "errors {wchk,lock,nodisk}", {err_wchk, err_lock, err_nodisk}, exp);
  endtask

  task automatic t_reset();
    chk_eq("R1", "busy", busy, 0);
    chk_eq("R1", "done", done, 0);
    chk_errs("R1", 3'b000);
    chk_eq("R1", "mem_req", mem_req, 0);
  endtask

  task automatic t_read_burst();
    logic [DA_W-1:0] da0 = 21'h00100;
    for (int i = 0; i < 5; i++) dsk[didx(da0 + DA_W'(i))] = 18'h01000 + 18'(i * 3);
    mem[100] = 18'h2AAAA; mem[106] = 18'h15555;
    set_ctl(18'h3FFFB, 18'd100);
    launch(2'd1, da0, 1'b1);
    wait_done();
    for (int i = 0; i < 5; i++)
      chk_eq("R3", "read word in memory", mem[101 + i], 18'h01000 + i * 3);
    chk_eq("R3", "word below block untouched", mem[100], 18'h2AAAA);
    chk_eq("R8", "word after last untouched", mem[106], 18'h15555);
    chk_eq("R2", "count at 036", mem[WCA], 0);
    chk_eq("R2", "address at 037", mem[CAA], 105);
    chk_eq("R8", "disk address advanced", dsk_addr, da0 + 5);
    chk_errs("R8", 3'b000);
    chk_eq("R8", "busy low at done", busy, 0);
  endtask

  task automatic t_wrap();
    logic [DA_W-1:0] da0 = 21'h00020;
    dsk[didx(da0)] = 18'h0BEEF;
    set_ctl(18'h3FFFF, 18'h3FFFF);
    launch(2'd1, da0, 1'b1);
    wait_done();
    chk_eq("R2", "count wraps to zero", mem[WCA], 0);
    chk_eq("R2", "address wraps at 15 bits", mem[CAA], 0);
    chk_eq("R3", "word landed at wrapped address", mem[0], 18'h0BEEF);
  endtask

  task automatic t_write_slots();
    logic [DA_W-1:0] da0 = {3'd2, 4'd3, 14'd50};
    for (int i = 0; i < 4; i++) begin
      mem[201 + i] = 18'h00700 + 18'(i);
      dsk[didx(da0 + DA_W'(i))] = 18'h3F000;
    end
    set_ctl(18'h3FFFC, 18'd200);
    strobe_en = 1'b0;
    launch(2'd2, da0, 1'b0);
    repeat (10) @(negedge clk);
    // start while busy must change nothing (R10)
    launch(2'd1, 21'h00300, 1'b1);
    repeat (30) @(negedge clk);
    chk_eq("R9", "busy while waiting for slot", busy, 1);
    chk_eq("R9", "only one count step without slot", mem[WCA], 18'h3FFFD);
    chk_eq("R4", "first word written", dsk[didx(da0)], 18'h00700);
    chk_eq("R9", "second word not yet written", dsk[didx(da0 + 1)], 18'h3F000);
    strobe_en = 1'b1;
    wait_done();
    strobe_en = 1'b0;
    for (int i = 0; i < 4; i++)
      chk_eq("R4", "disk word", dsk[didx(da0 + DA_W'(i))], 18'h00700 + i);
    chk_eq("R10", "ignored start left address", dsk_addr, da0 + 4);
    chk_eq("R2", "address at 037", mem[CAA], 204);
    chk_errs("R4", 3'b000);
  endtask

  task automatic t_check();
    logic [DA_W-1:0] da0 = {3'd3, 4'd0, 14'd10};
    for (int i = 0; i < 6; i++) begin
      mem[301 + i] = 18'h00500 + 18'(i);
      dsk[didx(da0 + DA_W'(i))] = 18'h00500 + 18'(i);
    end
    mem[303] = 18'h12345;
    set_ctl(18'h3FFFA, 18'd300);
    launch(2'd3, da0, 1'b1);
    wait_done();
    chk_errs("R5", 3'b100);
    chk_eq("R5", "address stops at mismatch", dsk_addr, da0 + 2);
    chk_eq("R5", "count stepped three times", mem[WCA], 18'h3FFFD);
    chk_eq("R5", "memory unchanged", mem[303], 18'h12345);
    chk_eq("R5", "disk unchanged", dsk[didx(da0 + 2)], 18'h00502);
  endtask

  task automatic t_lock();
    logic [DA_W-1:0] da0 = {3'd1, 4'd4, 14'h3FFE};
    logic [DA_W-1:0] lk  = {3'd1, 4'd5, 14'h0000};
    wlock = '0;
    wlock[1*16 + 5] = 1'b1;
    for (int i = 0; i < 5; i++) mem[401 + i] = 18'h00900 + 18'(i);
    dsk[didx(lk)] = 18'h2D2D2;
    set_ctl(18'h3FFFB, 18'd400);
    launch(2'd2, da0, 1'b1);
    wait_done();
    chk_errs("R6", 3'b010);
    chk_eq("R6", "words before lock written", dsk[didx(da0 + 1)], 18'h00901);
    chk_eq("R6", "locked word unchanged", dsk[didx(lk)], 18'h2D2D2);
    chk_eq("R6", "address not advanced", dsk_addr, lk);
    chk_eq("R6", "count stepped three times", mem[WCA], 18'h3FFFE);
    // read across the same locked group is allowed
    set_ctl(18'h3FFFE, 18'd450);
    launch(2'd1, lk, 1'b1);
    chk_eq("R12", "done cleared after start", done, 0);
    chk_errs("R12", 3'b000);
    wait_done();
    chk_errs("R6", 3'b000);
    chk_eq("R6", "read of locked group", mem[451], 18'h2D2D2);
    wlock = '0;
  endtask

  task automatic t_nodisk();
    logic [DA_W-1:0] da0 = 21'h7FFFE;
    plat_m1 = 3'd1;
    dsk[didx(da0)] = 18'h00111;
    dsk[didx(da0 + 1)] = 18'h00222;
    mem[503] = 18'h33333;
    set_ctl(18'h3FFFC, 18'd500);
    launch(2'd1, da0, 1'b1);
    wait_done();
    chk_errs("R7", 3'b001);
    chk_eq("R7", "address at capacity", dsk_addr, 21'h80000);
    chk_eq("R7", "count not stepped for failing word", mem[WCA], 18'h3FFFE);
    chk_eq("R7", "last word in range read", mem[502], 18'h00222);
    chk_eq("R7", "no move past capacity", mem[503], 18'h33333);
    plat_m1 = 3'd7;
  endtask

  task automatic t_null_op();
    launch(2'd0, 21'h0, 1'b1);
    chk_eq("R10", "op 0 not started", busy, 0);
    chk_eq("R10", "done kept after op 0", done, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      dsk[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_burst();
    t_wrap();
    t_write_slots();
    t_check();
    t_lock();
    t_nodisk();
    t_null_op();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL R8 global watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule